// File: doc/BRIEF.md
# Accumulator ALU Operation Unit

This unit carries out one 6-bit arithmetic opcode per issue against four accumulators (a, b, c, d) and a product register p. The register file sits outside the unit. Each issue presents the opcode together with the current register contents. One clock later the unit returns the new values, a write enable for each register it changes, and a pair of condition flags that persist between issues.

The opcode set mixes integer work with a simplified floating-point path. The integer operations are bitwise AND, left and arithmetic right shifts, and 24-bit add and subtract. The float operations are add, subtract and multiply. Several opcodes do two things in one issue: they fold the old product into c or d and load a fresh product a*b into p. Any opcode without an assigned meaning leaves every register and both flags untouched.

Float words carry an 8-bit two's-complement exponent in bits 31:24 and a 24-bit two's-complement mantissa in bits 23:0. The value is mantissa * 2^(exponent-23). A mantissa is normalized when bits 23 and 22 differ. A word whose mantissa is zero is zero. Results are truncated toward minus infinity, and exponent arithmetic wraps modulo 256.

Top module: `acc_alu_unit`

## Requirements
- R1: While rst_ni is low and after its release: done_o and all write enables are 0, zero_o and neg_o are 0, and a_o, c_o, d_o and p_o are 0.
- R2: Opcodes 0x00 and 0x01, and every opcode not named in R3 to R11, assert no write enable and leave both flags unchanged.
- R3: Opcode 0x02 writes c AND a to c. Opcode 0x03 writes d AND a to d. Both are full 32-bit operations.
- R4: Opcodes 0x2E and 0x2F write a shifted left to a, with the shift amount taken from bits 4:0 of c (0x2E) or of d (0x2F). Opcodes 0x30 and 0x31 write a arithmetically shifted right to a, with the amount from c (0x30) or d (0x31). Shifts write only a.
- R5: Opcodes 0x34, 0x35, 0x36 and 0x37 compute c+a, d+a, c-a and d-a respectively on bits 23:0, modulo 2^24. Bits 31:24 of the destination keep their old value.
- R6: Only opcodes 0x36 and 0x37 change the flags. They set zero_o when the 24-bit result is 0 and set neg_o to bit 23 of that result. zero_o and neg_o are never both 1.
- R7: Float add and subtract: 0x0C c=c+a, 0x0D d=d+a, 0x0E c=c-a, 0x0F d=d-a, 0x18 c=a+b, 0x19 d=a+b, 0x28 c=a-b, 0x29 d=a-b.
- R8: In float add and subtract, a zero operand counts as having exponent -128. The mantissa of the operand with the smaller exponent is arithmetically shifted right by the exponent difference; ties keep the first operand as the larger. The sum is then formed. A zero sum gives the word 0. A sum outside the 24-bit signed range is shifted right once and the exponent is incremented. Otherwise the sum is shifted left, and the exponent decremented, until bits 23 and 22 differ.
- R9: Opcodes 0x10 and 0x11 write the float product a*b to p. If either mantissa is zero the result is the word 0. Otherwise the 48-bit mantissa product is shifted left k places until bits 47 and 46 differ; bits 47:24 become the mantissa and the exponent is ea+eb+1-k.
- R10: Opcodes 0x12 (c+=p), 0x13 (d+=p), 0x14 (c-=p) and 0x15 (d-=p) use the incoming p as operand. In the same issue they write p with the float product a*b.
- R11: Opcodes 0x1A and 0x1B copy the incoming p into c or d respectively, and in the same issue write p with a*b.
- R12: Results, write enables and done_o appear on the clock edge after op_valid_i is sampled high. An edge with op_valid_i low gives done_o = 0, no write enable, and no change to the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Issue strobe for op_i and the operand inputs |
| op_i | input | 6 | Opcode |
| a_i | input | 32 | Current value of accumulator a |
| b_i | input | 32 | Current value of accumulator b |
| c_i | input | 32 | Current value of accumulator c |
| d_i | input | 32 | Current value of accumulator d |
| p_i | input | 32 | Current value of the product register |
| done_o | output | 1 | Result of an issue is present this cycle |
| a_we_o | output | 1 | Write enable for a |
| c_we_o | output | 1 | Write enable for c |
| d_we_o | output | 1 | Write enable for d |
| p_we_o | output | 1 | Write enable for p |
| a_o | output | 32 | New value for a |
| c_o | output | 32 | New value for c |
| d_o | output | 32 | New value for d |
| p_o | output | 32 | New value for p |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |

## Verification
Two functions can land in the same cycle: the float accumulate of c or d against the old product, and the new a*b multiply into p. The bench provokes this with back-to-back fused opcodes whose p input is unrelated to a*b, so any use of the new product in the accumulate changes the result. Each result is judged against a model that keeps the two computations separate: the c or d value is computed from the incoming p, and p is compared with a*b. Both are checked in the same result along with their write enables.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W = 6;

  typedef enum logic [3:0] {
    K_NOP,
    K_AND,
    K_SHL,
    K_SAR,
    K_IADD,
    K_ISUB,
    K_FACC,   // dst +/- a
    K_FAB,    // dst = a +/- b
    K_MUL,    // p = a*b
    K_FACCP,  // dst +/- old p, p = a*b
    K_MOVP    // dst = old p, p = a*b
  } alu_kind_e;

  typedef struct packed {
    alu_kind_e kind;
    logic      sub;
    logic      sel_d;
  } alu_ctrl_t;
endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output alu_ctrl_t       ctrl_o
);
  always_comb begin
    ctrl_o.kind  = K_NOP;
    ctrl_o.sub   = 1'b0;
    ctrl_o.sel_d = op_i[0];
    case (op_i)
      6'h02, 6'h03: ctrl_o.kind = K_AND;
      6'h0c, 6'h0d, 6'h0e, 6'h0f: begin
        ctrl_o.kind = K_FACC;
        ctrl_o.sub  = op_i[1];
      end
      6'h10, 6'h11: ctrl_o.kind = K_MUL;
      6'h12, 6'h13, 6'h14, 6'h15: begin
        ctrl_o.kind = K_FACCP;
        ctrl_o.sub  = op_i[2];
      end
      6'h18, 6'h19: ctrl_o.kind = K_FAB;
      6'h1a, 6'h1b: ctrl_o.kind = K_MOVP;
      6'h28, 6'h29: begin
        ctrl_o.kind = K_FAB;
        ctrl_o.sub  = 1'b1;
      end
      6'h2e, 6'h2f: ctrl_o.kind = K_SHL;
      6'h30, 6'h31: ctrl_o.kind = K_SAR;
      6'h34, 6'h35: ctrl_o.kind = K_IADD;
      6'h36, 6'h37: ctrl_o.kind = K_ISUB;
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_int.sv
module acc_alu_int
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADD_W  = 24,
  localparam int SHW   = $clog2(DATA_W)
) (
  input  alu_kind_e         kind_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [SHW-1:0]    amt_i,
  output logic [DATA_W-1:0] res_o,
  output logic [ADD_W-1:0]  sum_o
);
  logic [ADD_W-1:0] a_lo, d_lo;

  assign a_lo = ADD_W'(a_i);
  assign d_lo = ADD_W'(dst_i);

  always_comb begin
    sum_o = (kind_i == K_ISUB) ? d_lo - a_lo : d_lo + a_lo;
    case (kind_i)
      K_AND:          res_o = dst_i & a_i;
      K_SHL:          res_o = a_i << amt_i;
      K_SAR:          res_o = DATA_W'($signed(a_i) >>> amt_i);
      K_IADD, K_ISUB: res_o = {dst_i[DATA_W-1:ADD_W], sum_o};
      default:        res_o = dst_i;
    endcase
  end
endmodule

// File: rtl/acc_alu_fadd.sv
module acc_alu_fadd #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 24,
  localparam int W    = EXP_W + MAN_W,
  localparam int SW   = MAN_W + 2,
  localparam int CW   = $clog2(MAN_W) + 1
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  output logic [W-1:0] r_o
);
  localparam logic [EXP_W-1:0] EXP_MIN = {1'b1, {(EXP_W-1){1'b0}}};

  logic [MAN_W-1:0]        mx, my;
  logic [EXP_W-1:0]        ex, ey, er, e_out;
  logic signed [EXP_W:0]   diff;
  logic [EXP_W:0]          mag;
  logic [EXP_W:0]          sh;
  logic signed [SW-1:0]    xw, yw, xa, ya, s;
  logic [CW-1:0]           cnt;
  logic                    run, ovf;
  logic [MAN_W-1:0]        m_out;

  assign mx = MAN_W'(x_i);
  assign my = MAN_W'(y_i);
  // zero mantissa sorts below every real exponent
  assign ex = (mx == '0) ? EXP_MIN : x_i[W-1:MAN_W];
  assign ey = (my == '0) ? EXP_MIN : y_i[W-1:MAN_W];

  always_comb begin
    diff = $signed({ex[EXP_W-1], ex}) - $signed({ey[EXP_W-1], ey});
    mag  = diff[EXP_W] ? EXP_W'(0) - diff : diff;
    sh   = (mag > (EXP_W+1)'(SW)) ? (EXP_W+1)'(SW) : mag;
    xw   = SW'($signed(mx));
    yw   = SW'($signed(my));
    if (!diff[EXP_W]) begin
      er = ex;
      xa = xw;
      ya = yw >>> sh;
    end else begin
      er = ey;
      xa = xw >>> sh;
      ya = yw;
    end
    s   = sub_i ? xa - ya : xa + ya;
    ovf = !((s[SW-1] == s[SW-2]) && (s[SW-2] == s[MAN_W-1]));
    cnt = '0;
    run = 1'b1;
    for (int i = MAN_W - 2; i >= 0; i--) begin
      if (run && (s[i] == s[MAN_W-1])) cnt = cnt + 1'b1;
      else run = 1'b0;
    end
    if (s == '0) begin
      m_out = '0;
      e_out = '0;
    end else if (ovf) begin
      m_out = MAN_W'(s >>> 1);
      e_out = er + 1'b1;
    end else begin
      m_out = MAN_W'(s) << cnt;
      e_out = er - EXP_W'(cnt);
    end
    r_o = {e_out, m_out};
  end
endmodule

// File: rtl/acc_alu_fmul.sv
module acc_alu_fmul #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 24,
  localparam int W    = EXP_W + MAN_W,
  localparam int PW   = 2 * MAN_W,
  localparam int CW   = $clog2(PW) + 1
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] r_o
);
  logic signed [MAN_W-1:0] mx, my;
  logic signed [PW-1:0]    prod, norm;
  logic [CW-1:0]           cnt;
  logic                    run;
  logic [EXP_W-1:0]        e_out;

  assign mx = $signed(x_i[MAN_W-1:0]);
  assign my = $signed(y_i[MAN_W-1:0]);

  always_comb begin
    prod = PW'(mx) * PW'(my);
    cnt  = '0;
    run  = 1'b1;
    for (int i = PW - 2; i >= 0; i--) begin
      if (run && (prod[i] == prod[PW-1])) cnt = cnt + 1'b1;
      else run = 1'b0;
    end
    norm  = prod << cnt;
    e_out = x_i[W-1:MAN_W] + y_i[W-1:MAN_W] + 1'b1 - EXP_W'(cnt);
    if (mx == '0 || my == '0) r_o = '0;
    else r_o = {e_out, MAN_W'(norm >>> MAN_W)};
  end
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_alu_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 24,
  localparam int DATA_W = EXP_W + MAN_W,
  localparam int SHW    = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  input  logic [DATA_W-1:0] d_i,
  input  logic [DATA_W-1:0] p_i,
  output logic              done_o,
  output logic              a_we_o,
  output logic              c_we_o,
  output logic              d_we_o,
  output logic              p_we_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] c_o,
  output logic [DATA_W-1:0] d_o,
  output logic [DATA_W-1:0] p_o,
  output logic              zero_o,
  output logic              neg_o
);
  alu_ctrl_t         ctrl;
  logic [DATA_W-1:0] dst_old, int_res, fadd_x, fadd_y, fadd_r, fmul_r, cd_next;
  logic [MAN_W-1:0]  int_sum;
  logic              wr_a, wr_cd, wr_p, wr_flags;

  acc_alu_decode u_dec (
    .op_i  (op_i),
    .ctrl_o(ctrl)
  );

  assign dst_old = ctrl.sel_d ? d_i : c_i;

  acc_alu_int #(.DATA_W(DATA_W), .ADD_W(MAN_W)) u_int (
    .kind_i(ctrl.kind),
    .a_i   (a_i),
    .dst_i (dst_old),
    .amt_i (SHW'(dst_old)),
    .res_o (int_res),
    .sum_o (int_sum)
  );

  // one adder serves every float accumulate form
  always_comb begin
    fadd_x = (ctrl.kind == K_FAB) ? a_i : dst_old;
    case (ctrl.kind)
      K_FACC:  fadd_y = a_i;
      K_FAB:   fadd_y = b_i;
      default: fadd_y = p_i;
    endcase
  end

  acc_alu_fadd #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_fadd (
    .x_i  (fadd_x),
    .y_i  (fadd_y),
    .sub_i(ctrl.sub),
    .r_o  (fadd_r)
  );

  acc_alu_fmul #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_fmul (
    .x_i(a_i),
    .y_i(b_i),
    .r_o(fmul_r)
  );

  always_comb begin
    wr_a     = (ctrl.kind == K_SHL) || (ctrl.kind == K_SAR);
    wr_p     = (ctrl.kind == K_MUL) || (ctrl.kind == K_FACCP) || (ctrl.kind == K_MOVP);
    wr_flags = (ctrl.kind == K_ISUB);
    case (ctrl.kind)
      K_AND, K_IADD, K_ISUB: begin wr_cd = 1'b1; cd_next = int_res; end
      K_FACC, K_FAB, K_FACCP: begin wr_cd = 1'b1; cd_next = fadd_r; end
      K_MOVP:                begin wr_cd = 1'b1; cd_next = p_i; end
      default:               begin wr_cd = 1'b0; cd_next = dst_old; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      a_we_o <= 1'b0;
      c_we_o <= 1'b0;
      d_we_o <= 1'b0;
      p_we_o <= 1'b0;
      a_o    <= '0;
      c_o    <= '0;
      d_o    <= '0;
      p_o    <= '0;
      zero_o <= 1'b0;
      neg_o  <= 1'b0;
    end else begin
      done_o <= op_valid_i;
      a_we_o <= op_valid_i && wr_a;
      c_we_o <= op_valid_i && wr_cd && !ctrl.sel_d;
      d_we_o <= op_valid_i && wr_cd && ctrl.sel_d;
      p_we_o <= op_valid_i && wr_p;
      if (op_valid_i && wr_a) a_o <= int_res;
      if (op_valid_i && wr_cd && !ctrl.sel_d) c_o <= cd_next;
      if (op_valid_i && wr_cd && ctrl.sel_d) d_o <= cd_next;
      if (op_valid_i && wr_p) p_o <= fmul_r;
      if (op_valid_i && wr_flags) begin
        zero_o <= (int_sum == '0);
        neg_o  <= int_sum[MAN_W-1];
      end
    end
  end
endmodule

// File: rtl/acc_alu_unit_chk.sv
module acc_alu_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       op_valid_i,
  input logic [5:0] op_i,
  input logic       done_o,
  input logic       a_we_o,
  input logic       c_we_o,
  input logic       d_we_o,
  input logic       p_we_o,
  input logic       zero_o,
  input logic       neg_o
);
  logic any_we;
  logic flag_op, fused_op, nop_op;

  assign any_we   = a_we_o || c_we_o || d_we_o || p_we_o;
  assign flag_op  = op_valid_i && (op_i == 6'h36 || op_i == 6'h37);
  assign fused_op = op_valid_i && ((op_i >= 6'h12 && op_i <= 6'h15) || op_i == 6'h1a || op_i == 6'h1b);
  assign nop_op   = op_valid_i && (op_i == 6'h00 || op_i == 6'h01);

  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> !any_we && !done_o); // R12
  AST_DONE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> done_o); // R12
  AST_NOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nop_op |=> !any_we); // R2
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_op |=> $stable({zero_o, neg_o})); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(zero_o && neg_o)); // R6
  AST_FUSED_TWO_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fused_op |=> p_we_o && (c_we_o || d_we_o)); // R10
  AST_SHIFT_ONLY_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_we_o |-> !(c_we_o || d_we_o || p_we_o)); // R4
  AST_ONE_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({c_we_o, d_we_o})); // R5
endmodule

bind acc_alu_unit acc_alu_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_valid_i(op_valid_i),
  .op_i      (op_i),
  .done_o    (done_o),
  .a_we_o    (a_we_o),
  .c_we_o    (c_we_o),
  .d_we_o    (d_we_o),
  .p_we_o    (p_we_o),
  .zero_o    (zero_o),
  .neg_o     (neg_o)
);

// File: tb/tb_acc_alu_unit.sv
`timescale 1ns/1ps
module tb_acc_alu_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [5:0] op = '0;
  logic [31:0] a = '0, b = '0, c = '0, d = '0, p = '0;
  logic done_o, a_we_o, c_we_o, d_we_o, p_we_o, zero_o, neg_o;
  logic [31:0] a_o, c_o, d_o, p_o;

  always #10 clk = ~clk;

  acc_alu_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op),
    .a_i(a), .b_i(b), .c_i(c), .d_i(d), .p_i(p),
    .done_o(done_o), .a_we_o(a_we_o), .c_we_o(c_we_o), .d_we_o(d_we_o), .p_we_o(p_we_o),
    .a_o(a_o), .c_o(c_o), .d_o(d_o), .p_o(p_o), .zero_o(zero_o), .neg_o(neg_o)
  );

  typedef struct {
    logic [5:0]  op;
    logic [3:0]  we;    // a c d p
    logic [31:0] va, vc, vd, vp;
    logic [1:0]  fl;    // zero neg
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errs = 0;
  bit fz = 0, fn = 0;

  function automatic logic [31:0] m_fadd(logic [31:0] x, logic [31:0] y, bit sub);
    longint mx = longint'($signed(x[23:0]));
    longint my = longint'($signed(y[23:0]));
    longint ex = longint'($signed(x[31:24]));
    longint ey = longint'($signed(y[31:24]));
    longint er, s;
    if (mx == 0) ex = -128;
    if (my == 0) ey = -128;
    if (ex >= ey) begin er = ex; my = my >>> ((ex - ey) > 31 ? 31 : (ex - ey)); end
    else begin er = ey; mx = mx >>> ((ey - ex) > 31 ? 31 : (ey - ex)); end
    s = sub ? mx - my : mx + my;
    if (s == 0) return 32'h0;
    if (s > 8388607 || s < -8388608) begin s = s >>> 1; er = er + 1; end
    else while (s < 4194304 && s >= -4194304) begin s = s * 2; er = er - 1; end
    return {8'(er), 24'(s)};
  endfunction

  function automatic logic [31:0] m_fmul(logic [31:0] x, logic [31:0] y);
    longint mx = longint'($signed(x[23:0]));
    longint my = longint'($signed(y[23:0]));
    longint pr, e;
    int k = 0;
    if (mx == 0 || my == 0) return 32'h0;
    pr = mx * my;
    while (pr < 64'sd70368744177664 && pr >= -64'sd70368744177664) begin pr = pr * 2; k++; end
    e = longint'($signed(x[31:24])) + longint'($signed(y[31:24])) + 1 - k;
    return {8'(e), 24'(pr >>> 24)};
  endfunction

  function automatic string tag_of(logic [5:0] o);
    case (o)
      6'h02, 6'h03: return "R3";
      6'h2e, 6'h2f, 6'h30, 6'h31: return "R4";
      6'h34, 6'h35: return "R5";
      6'h36, 6'h37: return "R5/R6";
      6'h0c, 6'h0d, 6'h0e, 6'h0f, 6'h18, 6'h19, 6'h28, 6'h29: return "R7/R8";
      6'h10, 6'h11: return "R9";
      6'h12, 6'h13, 6'h14, 6'h15: return "R10";
      6'h1a, 6'h1b: return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic issue(logic [5:0] o, logic [31:0] ra, logic [31:0] rb,
                       logic [31:0] rc, logic [31:0] rd, logic [31:0] rp);
    exp_t e;
    logic [31:0] dst;
    logic [23:0] s24;
    @(negedge clk);
    op = o; a = ra; b = rb; c = rc; d = rd; p = rp; op_valid = 1'b1;
    dst = o[0] ? rd : rc;
    e.op = o; e.we = 4'b0000; e.va = 0; e.vc = 0; e.vd = 0; e.vp = 0; e.tag = tag_of(o);
    case (o)
      6'h02, 6'h03: begin e.we = o[0] ? 4'b0010 : 4'b0100; e.vc = rc & ra; e.vd = rd & ra; end
      6'h2e, 6'h2f: begin e.we = 4'b1000; e.va = ra << dst[4:0]; end
      6'h30, 6'h31: begin e.we = 4'b1000; e.va = $signed(ra) >>> dst[4:0]; end
      6'h34, 6'h35, 6'h36, 6'h37: begin
        s24 = o[1] ? dst[23:0] - ra[23:0] : dst[23:0] + ra[23:0];
        e.we = o[0] ? 4'b0010 : 4'b0100;
        e.vc = {dst[31:24], s24}; e.vd = e.vc;
        if (o[1]) begin fz = (s24 == 0); fn = s24[23]; end
      end
      6'h0c, 6'h0d, 6'h0e, 6'h0f: begin
        e.we = o[0] ? 4'b0010 : 4'b0100; e.vc = m_fadd(dst, ra, o[1]); e.vd = e.vc;
      end
      6'h18, 6'h19, 6'h28, 6'h29: begin
        e.we = o[0] ? 4'b0010 : 4'b0100; e.vc = m_fadd(ra, rb, o[5]); e.vd = e.vc;
      end
      6'h10, 6'h11: begin e.we = 4'b0001; e.vp = m_fmul(ra, rb); end
      6'h12, 6'h13, 6'h14, 6'h15: begin
        e.we = o[0] ? 4'b0011 : 4'b0101; e.vc = m_fadd(dst, rp, o[2]); e.vd = e.vc;
        e.vp = m_fmul(ra, rb);
      end
      6'h1a, 6'h1b: begin
        e.we = o[0] ? 4'b0011 : 4'b0101; e.vc = rp; e.vd = rp; e.vp = m_fmul(ra, rb);
      end
      default: ;
    endcase
    e.fl = {fz, fn};
    q.push_back(e);
  endtask

  // monitor: pop one expected item per result
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n && done_o) begin
        exp_t e;
        bit bad;
        checks++;
        if (q.size() == 0) begin
          errs++;
          $display("FAIL R12: unexpected result actual done=1 expected no pending issue");
        end else begin
          e = q.pop_front();
          bad = ({a_we_o, c_we_o, d_we_o, p_we_o} != e.we) || ({zero_o, neg_o} != e.fl);
          if (e.we[3] && a_o != e.va) bad = 1;
          if (e.we[2] && c_o != e.vc) bad = 1;
          if (e.we[1] && d_o != e.vd) bad = 1;
          if (e.we[0] && p_o != e.vp) bad = 1;
          if (bad) begin
            errs++;
            $display("FAIL %s op=%02h: actual we=%b a=%h c=%h d=%h p=%h fl=%b expected we=%b a=%h c=%h d=%h p=%h fl=%b",
                     e.tag, e.op, {a_we_o, c_we_o, d_we_o, p_we_o}, a_o, c_o, d_o, p_o, {zero_o, neg_o},
                     e.we, e.va, e.vc, e.vd, e.vp, e.fl);
          end
        end
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R12: watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1 during reset
    if ({done_o, a_we_o, c_we_o, d_we_o, p_we_o, zero_o, neg_o} != 0 || {a_o, c_o, d_o, p_o} != 0) begin
      errs++;
      $display("FAIL R1: actual ctl=%b data=%h expected all zero",
               {done_o, a_we_o, c_we_o, d_we_o, p_we_o, zero_o, neg_o}, {a_o, c_o, d_o, p_o});
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;  // R1 after release, idle
    if ({done_o, a_we_o, c_we_o, d_we_o, p_we_o, zero_o, neg_o} != 0) begin
      errs++;
      $display("FAIL R1: actual ctl=%b expected 0", {done_o, a_we_o, c_we_o, d_we_o, p_we_o, zero_o, neg_o});
    end

    // R3 AND
    issue(6'h02, 32'h0ff0ff00, 0, 32'hf0f01234, 0, 0);
    issue(6'h03, 32'hffff0000, 0, 0, 32'h12345678, 0);
    // R4 shifts
    issue(6'h2e, 32'h00000003, 0, 32'h00000024, 0, 0);
    issue(6'h31, 32'h80000000, 0, 0, 32'h0000001f, 0);
    issue(6'h30, 32'hf0000000, 0, 32'hffffffe1, 0, 0);
    issue(6'h2f, 32'h12345678, 0, 0, 32'h00000000, 0);
    // R5/R6 integer 24-bit
    issue(6'h34, 32'h00000001, 0, 32'hab7fffff, 0, 0);
    issue(6'h36, 32'h00000005, 0, 32'h12000005, 0, 0);
    issue(6'h02, 32'h0, 0, 32'h5, 0, 0);        // flags held (R6)
    issue(6'h37, 32'h00000001, 0, 0, 32'h77000000, 0);
    issue(6'h35, 32'h00000001, 0, 0, 32'h00ffffff, 0);  // wraps, flags held
    issue(6'h37, 32'h00000001, 0, 0, 32'h00000002, 0);
    // R7/R8 float add and subtract
    issue(6'h0c, 32'h01400000, 0, 32'h01400000, 0, 0);
    issue(6'h0e, 32'h025a0000, 0, 32'h025a0000, 0, 0);
    issue(6'h18, 32'h03600000, 32'h00400000, 0, 0, 0);
    issue(6'h29, 32'h00400000, 32'h02600000, 0, 0, 0);
    issue(6'h0d, 32'h00000000, 0, 0, 32'h05700000, 0);
    issue(6'h0f, 32'h00800000, 0, 0, 32'h00400000, 0);
    issue(6'h0c, 32'h7f400000, 0, 32'hfd400000, 0, 0);
    issue(6'h28, 32'h00400000, 32'h00600000, 0, 0, 0);
    // R9 multiply
    issue(6'h10, 32'h01400000, 32'h02600000, 0, 0, 0);
    issue(6'h11, 32'h00800000, 32'h00800000, 0, 0, 0);
    issue(6'h10, 32'h00000000, 32'h02600000, 0, 0, 0);
    issue(6'h11, 32'hffa00000, 32'h04500000, 0, 0, 0);
    // R10/R11 fused, p unrelated to a*b
    issue(6'h12, 32'h01500000, 32'h01600000, 32'h00400000, 0, 32'h01400000);
    issue(6'h13, 32'hff800000, 32'h00400000, 0, 32'h03700000, 32'h00a00000);
    issue(6'h14, 32'h02400000, 32'h02400000, 32'h00400000, 0, 32'h00400000);
    issue(6'h15, 32'h00600000, 32'hfe900000, 0, 32'h10400000, 32'h0f600000);
    issue(6'h1a, 32'h01400000, 32'h01400000, 32'h11111111, 0, 32'h7e5a5a5a);
    issue(6'h1b, 32'h00700000, 32'h00900000, 0, 32'h22222222, 32'h81a5a5a5);
    // R2 no-ops and unassigned codes
    issue(6'h00, 32'hffffffff, 32'hffffffff, 32'hffffffff, 32'hffffffff, 32'hffffffff);
    issue(6'h01, 1, 2, 3, 4, 5);
    issue(6'h04, 1, 2, 3, 4, 5);
    issue(6'h20, 1, 2, 3, 4, 5);
    issue(6'h3f, 1, 2, 3, 4, 5);
    // mixed sweep over all opcodes
    for (int i = 0; i < 120; i++) begin
      logic [5:0] o;
      o = 6'(i * 37);
      issue(o, $urandom, $urandom, $urandom, $urandom, $urandom);
    end
    @(negedge clk);
    op_valid = 1'b0;
    repeat (3) @(negedge clk);
    checks++;  // R12 idle gives nothing
    if (done_o || a_we_o || c_we_o || d_we_o || p_we_o || q.size() != 0) begin
      errs++;
      $display("FAIL R12: actual done=%b we=%b pending=%0d expected 0 0000 0",
               done_o, {a_we_o, c_we_o, d_we_o, p_we_o}, q.size());
    end
    summary();
    $finish;
  end
endmodule